// File: doc/BRIEF.md
# Vector Load/Store Immediate Generator

This block produces the displacement that one element of a vectorised load or store adds to its base address. It takes the raw displacement field of the instruction, the form of that field (a plain 16-bit displacement, or a 14-bit displacement counted in 4-byte units), a stride mode, the load/store direction, the element and sub-element positions of the current element, and an optional remapped element index. From these it derives a flattened element number, scales the displacement by it according to the stride mode, and presents the result one clock later as a 32-bit immediate together with a flag that says whether the displacement was rewritten.

The datapath is purely combinational. A single register stage sits behind it, under a two-state output machine. `OUT_IDLE` means no result is presented. `OUT_VALID` means the registered immediate belongs to the request accepted on the previous edge. The transitions are named as follows. *accept* goes from either state to `OUT_VALID` whenever `in_valid` is high. *drain* goes from either state to `OUT_IDLE` whenever `in_valid` is low. Reset forces `OUT_IDLE` and clears the registered immediate and flag. Address addition, register reads and the memory access belong to neighbouring logic.

Top module: `vlsimm_gen`

## Requirements
- R1: With `ds_form`=0 and a non-stride mode, `eff_imm` is the 16-bit `disp_raw` sign-extended to 32 bits and `replaced` is 0.
- R2: With `ds_form`=1, the displacement field is `disp_raw[13:0]`. The stride arithmetic uses that field sign-extended and multiplied by 4. In a non-stride mode, `eff_imm` is the 14-bit field sign-extended to 32 bits.
- R3: For a load (`is_store`=0), the element multiplier is `src_step*(sub_len+1)+src_sub`. When `remap_en`=1, the multiplier is `remap_idx` instead.
- R4: For a store (`is_store`=1), the element multiplier is `dst_step*(sub_len+1)+dst_sub`. `remap_en` and `remap_idx` have no effect on a store.
- R5: Mode `ls_mode`=2'b01 is unit stride. The result is displacement + multiplier × 2^`width_log2`, truncated to 32 bits, and `replaced`=1. `width_log2` encodes 0=1, 1=2, 2=4 and 3=8 bytes.
- R6: Mode `ls_mode`=2'b10 is element stride. The result is displacement × multiplier, truncated to 32 bits, and `replaced`=1. A multiplier of zero gives zero.
- R7: Modes 2'b00 and 2'b11 pass the displacement through unchanged and leave `replaced`=0.
- R8: When `ds_form`=1 and the result was replaced, the 32-bit result is shifted right logically by 2 before output.
- R9: `out_valid` equals `in_valid` of the previous edge. `eff_imm` and `replaced` change only on an edge where `in_valid`=1. Reset clears `out_valid`, `eff_imm` and `replaced`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| disp_raw | input | 16 | Raw displacement field |
| ds_form | input | 1 | 1 selects the 14-bit, 4-byte-unit field |
| ls_mode | input | 2 | 00/11 plain, 01 unit stride, 10 element stride |
| is_store | input | 1 | 1 for store, 0 for load |
| src_step | input | 7 | Source element step |
| dst_step | input | 7 | Destination element step |
| src_sub | input | 2 | Source sub-element step |
| dst_sub | input | 2 | Destination sub-element step |
| sub_len | input | 2 | Sub-vector length minus one |
| remap_en | input | 1 | Use remapped source index (loads only) |
| remap_idx | input | 7 | Remapped source index |
| width_log2 | input | 2 | log2 of access width in bytes |
| out_valid | output | 1 | Result strobe |
| eff_imm | output | 32 | Effective immediate |
| replaced | output | 1 | Immediate was rewritten by a stride mode |

## Verification
A wrong output-machine state shows on `out_valid` in the very next cycle, because the strobe must track the previous cycle's `in_valid` exactly. A wrong multiplier or scaling path shows on `eff_imm` one cycle after the request, but only in a stride mode. For that reason the requests mix loads, stores, remapped loads, sub-vector lengths and both field forms. A register that captures data while idle shows as `eff_imm` or `replaced` moving during a gap between requests, so the bench compares the held values on every idle cycle as well.

// File: rtl/vlsimm_pkg.sv
package vlsimm_pkg;

    typedef enum logic [1:0] {
        LS_PLAIN     = 2'b00,
        LS_UNIT      = 2'b01,
        LS_ELEM      = 2'b10,
        LS_PLAIN_ALT = 2'b11
    } ls_mode_e;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_VALID = 1'b1
    } out_state_e;

endpackage

// File: rtl/vlsimm_index.sv
module vlsimm_index #(
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2,
    parameter int MULT_W = STEP_W + SUB_W
) (
    input  logic              is_store,
    input  logic [STEP_W-1:0] src_step,
    input  logic [STEP_W-1:0] dst_step,
    input  logic [SUB_W-1:0]  src_sub,
    input  logic [SUB_W-1:0]  dst_sub,
    input  logic [SUB_W-1:0]  sub_len,
    input  logic              remap_en,
    input  logic [STEP_W-1:0] remap_idx,
    output logic [MULT_W-1:0] mult
);
    localparam int SIDES = 2;

    logic [STEP_W-1:0] step_arr [SIDES];
    logic [SUB_W-1:0]  sub_arr  [SIDES];
    logic [MULT_W-1:0] flat     [SIDES];
    logic [MULT_W-1:0] grp;

    assign step_arr[0] = src_step;
    assign step_arr[1] = dst_step;
    assign sub_arr[0]  = src_sub;
    assign sub_arr[1]  = dst_sub;
    assign grp         = MULT_W'(sub_len) + MULT_W'(1);

    // element number flattened across sub-elements, one per side
    for (genvar g = 0; g < SIDES; g++) begin : g_side
        assign flat[g] = MULT_W'(step_arr[g]) * grp + MULT_W'(sub_arr[g]);
    end

    // stores never take the remapped index (R4); loads may (R3)
    always_comb begin
        if (is_store)
            mult = flat[1];
        else if (remap_en)
            mult = MULT_W'(remap_idx);
        else
            mult = flat[0];
    end

endmodule

// File: rtl/vlsimm_scale.sv
module vlsimm_scale
    import vlsimm_pkg::*;
#(
    parameter int DISP_W = 16,
    parameter int IMM_W  = 32,
    parameter int MULT_W = 9,
    parameter int WLOG_W = 2
) (
    input  logic [DISP_W-1:0] disp_raw,
    input  logic              ds_form,
    input  ls_mode_e          mode,
    input  logic [MULT_W-1:0] mult,
    input  logic [WLOG_W-1:0] width_log2,
    output logic [IMM_W-1:0]  imm,
    output logic              replaced
);
    localparam int DS_W  = DISP_W - 2;
    localparam int EXT_D = IMM_W - DISP_W;
    localparam int EXT_S = IMM_W - DS_W;

    logic [IMM_W-1:0] pass_val;
    logic [IMM_W-1:0] base_val;
    logic [IMM_W-1:0] mult_ext;
    logic [IMM_W-1:0] raw_res;

    always_comb begin
        mult_ext = IMM_W'(mult);
        if (ds_form) begin
            pass_val = {{EXT_S{disp_raw[DS_W-1]}}, disp_raw[DS_W-1:0]};
            base_val = {{EXT_D{disp_raw[DS_W-1]}}, disp_raw[DS_W-1:0], 2'b00};
        end else begin
            pass_val = {{EXT_D{disp_raw[DISP_W-1]}}, disp_raw};
            base_val = pass_val;
        end

        unique case (mode)
            LS_UNIT: begin
                raw_res  = base_val + (mult_ext << width_log2);
                replaced = 1'b1;
            end
            LS_ELEM: begin
                raw_res  = base_val * mult_ext;
                replaced = 1'b1;
            end
            LS_PLAIN, LS_PLAIN_ALT: begin
                raw_res  = pass_val;
                replaced = 1'b0;
            end
        endcase

        // a rewritten 4-byte-unit field goes back to its own units (R8)
        imm = (replaced && ds_form) ? (raw_res >> 2) : raw_res;
    end

endmodule

// File: rtl/vlsimm_gen.sv
module vlsimm_gen
    import vlsimm_pkg::*;
#(
    parameter int DISP_W = 16,
    parameter int IMM_W  = 32,
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2,
    parameter int WLOG_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DISP_W-1:0] disp_raw,
    input  logic              ds_form,
    input  logic [1:0]        ls_mode,
    input  logic              is_store,
    input  logic [STEP_W-1:0] src_step,
    input  logic [STEP_W-1:0] dst_step,
    input  logic [SUB_W-1:0]  src_sub,
    input  logic [SUB_W-1:0]  dst_sub,
    input  logic [SUB_W-1:0]  sub_len,
    input  logic              remap_en,
    input  logic [STEP_W-1:0] remap_idx,
    input  logic [WLOG_W-1:0] width_log2,
    output logic              out_valid,
    output logic [IMM_W-1:0]  eff_imm,
    output logic              replaced
);
    localparam int MULT_W = STEP_W + SUB_W;

    logic [MULT_W-1:0] mult;
    logic [IMM_W-1:0]  imm_c;
    logic              rep_c;
    logic [IMM_W-1:0]  imm_q;
    logic              rep_q;
    out_state_e        state_q, state_d;

    vlsimm_index #(
        .STEP_W(STEP_W),
        .SUB_W (SUB_W),
        .MULT_W(MULT_W)
    ) u_index (
        .is_store (is_store),
        .src_step (src_step),
        .dst_step (dst_step),
        .src_sub  (src_sub),
        .dst_sub  (dst_sub),
        .sub_len  (sub_len),
        .remap_en (remap_en),
        .remap_idx(remap_idx),
        .mult     (mult)
    );

    vlsimm_scale #(
        .DISP_W(DISP_W),
        .IMM_W (IMM_W),
        .MULT_W(MULT_W),
        .WLOG_W(WLOG_W)
    ) u_scale (
        .disp_raw  (disp_raw),
        .ds_form   (ds_form),
        .mode      (ls_mode_e'(ls_mode)),
        .mult      (mult),
        .width_log2(width_log2),
        .imm       (imm_c),
        .replaced  (rep_c)
    );

    // next state: accept / drain
    always_comb begin
        unique case (state_q)
            OUT_IDLE:  state_d = in_valid ? OUT_VALID : OUT_IDLE;
            OUT_VALID: state_d = in_valid ? OUT_VALID : OUT_IDLE;
        endcase
    end

    // state register and captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
            imm_q   <= '0;
            rep_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                imm_q <= imm_c;
                rep_q <= rep_c;
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = (state_q == OUT_VALID);
        eff_imm   = imm_q;
        replaced  = rep_q;
    end

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r9_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(eff_imm) && $stable(replaced)));
    a_r7_plain_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (ls_mode == 2'b00 || ls_mode == 2'b11)) |=> !replaced);
    a_r5_stride_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (ls_mode == 2'b01 || ls_mode == 2'b10)) |=> replaced);
    a_r6_zero_mult: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ls_mode == 2'b10 && !is_store && remap_en && remap_idx == '0)
        |=> (eff_imm == '0));

endmodule

// File: tb/sim_vlsimm_gen.sv
module sim_vlsimm_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] disp_raw = '0;
    logic        ds_form = 1'b0;
    logic [1:0]  ls_mode = '0;
    logic        is_store = 1'b0;
    logic [6:0]  src_step = '0;
    logic [6:0]  dst_step = '0;
    logic [1:0]  src_sub = '0;
    logic [1:0]  dst_sub = '0;
    logic [1:0]  sub_len = '0;
    logic        remap_en = 1'b0;
    logic [6:0]  remap_idx = '0;
    logic [1:0]  width_log2 = '0;
    logic        out_valid;
    logic [31:0] eff_imm;
    logic        replaced;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] imm;
        logic        rep;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] held_imm = '0;
    logic        held_rep = 1'b0;
    string       held_req = "R9";

    always #10 clk = ~clk;

    vlsimm_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .disp_raw(disp_raw),
        .ds_form(ds_form), .ls_mode(ls_mode), .is_store(is_store),
        .src_step(src_step), .dst_step(dst_step), .src_sub(src_sub),
        .dst_sub(dst_sub), .sub_len(sub_len), .remap_en(remap_en),
        .remap_idx(remap_idx), .width_log2(width_log2),
        .out_valid(out_valid), .eff_imm(eff_imm), .replaced(replaced)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // behavioural reference computed from the requirements
    function automatic void model(input logic [15:0] d, input bit dsf,
        input logic [1:0] m, input bit st, input int ss, input int dstp,
        input int su, input int du, input int sl, input bit re, input int ri,
        input int w, output logic [31:0] res, output logic rep);
        longint sv, base, mlt, r;
        logic [63:0] t;
        if (dsf) begin
            sv = longint'(d[13:0]);
            if (sv >= 8192) sv -= 16384;
            base = sv * 4;
        end else begin
            sv = longint'(d);
            if (sv >= 32768) sv -= 65536;
            base = sv;
        end
        if (st) mlt = dstp * (sl + 1) + du;
        else if (re) mlt = ri;
        else mlt = ss * (sl + 1) + su;
        rep = 1'b1;
        if (m == 2'b01) r = base + mlt * (longint'(1) << w);
        else if (m == 2'b10) r = base * mlt;
        else begin r = sv; rep = 1'b0; end
        t = r;
        res = t[31:0];
        if (rep && dsf) res = res >> 2;
    endfunction

    // compare outputs, then drive the next request, both at the falling edge
    task automatic cycle(input bit v, input logic [15:0] d, input bit dsf,
        input logic [1:0] m, input bit st, input int ss, input int dstp,
        input int su, input int du, input int sl, input bit re, input int ri,
        input int w, input string req);
        exp_t e;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            chk(out_valid === 1'b1, e.req, "out_valid", longint'(out_valid), 1);
            chk(eff_imm === e.imm, e.req, "eff_imm", longint'(eff_imm), longint'(e.imm));
            chk(replaced === e.rep, e.req, "replaced", longint'(replaced), longint'(e.rep));
            held_imm = e.imm; held_rep = e.rep;
        end else begin
            chk(out_valid === 1'b0, "R9", "out_valid idle", longint'(out_valid), 0);
            chk(eff_imm === held_imm, "R9", "eff_imm hold", longint'(eff_imm), longint'(held_imm));
            chk(replaced === held_rep, "R9", "replaced hold", longint'(replaced), longint'(held_rep));
        end
        in_valid = v; disp_raw = d; ds_form = dsf; ls_mode = m; is_store = st;
        src_step = 7'(ss); dst_step = 7'(dstp); src_sub = 2'(su); dst_sub = 2'(du);
        sub_len = 2'(sl); remap_en = re; remap_idx = 7'(ri); width_log2 = 2'(w);
        if (v) begin
            model(d, dsf, m, st, ss, dstp, su, du, sl, re, ri, w, e.imm, e.rep);
            e.req = req;
            exp_q.push_back(e);
        end
    endtask

    task automatic idle();
        cycle(0, 16'h5a5a, 1, 2'b01, 0, 9, 9, 1, 1, 3, 0, 0, 3, "R9");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // reset state (R9)
        chk(out_valid === 1'b0, "R9", "reset out_valid", longint'(out_valid), 0);
        chk(eff_imm === 32'h0, "R9", "reset eff_imm", longint'(eff_imm), 0);
        chk(replaced === 1'b0, "R9", "reset replaced", longint'(replaced), 0);
        rst_n = 1'b1;

        cycle(1, 16'h8001, 0, 2'b00, 0, 5, 6, 1, 2, 3, 0, 0, 3, "R1");
        cycle(1, 16'h2000, 1, 2'b00, 0, 5, 6, 1, 2, 3, 0, 0, 3, "R2");
        cycle(1, 16'h1234, 0, 2'b11, 1, 5, 6, 1, 2, 3, 1, 4, 1, "R7");
        cycle(1, 16'd16,   0, 2'b01, 0, 3, 0, 1, 0, 1, 0, 0, 3, "R3 R5");
        cycle(1, 16'hfffc, 0, 2'b10, 0, 3, 0, 1, 0, 1, 1, 5, 0, "R3 R6");
        cycle(1, 16'd100,  0, 2'b10, 1, 1, 2, 3, 0, 0, 1, 9, 0, "R4");
        cycle(1, 16'd100,  0, 2'b01, 1, 7, 4, 0, 3, 3, 1, 99, 2, "R4 R5");
        idle();
        idle();
        cycle(1, 16'h0003, 1, 2'b01, 0, 1, 0, 0, 0, 0, 0, 0, 2, "R8");
        cycle(1, 16'h3fff, 1, 2'b10, 0, 3, 0, 0, 0, 0, 0, 0, 0, "R8");
        cycle(1, 16'h7fff, 0, 2'b10, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
        cycle(1, 16'h7fff, 0, 2'b10, 0, 127, 0, 3, 0, 3, 0, 0, 0, "R6");
        cycle(1, 16'h8000, 1, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        idle();

        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            m = 2'($urandom);
            if ($urandom_range(0, 4) == 0) idle();
            else cycle(1, 16'($urandom), 1'($urandom), m, 1'($urandom),
                       $urandom_range(0, 127), $urandom_range(0, 127),
                       $urandom_range(0, 3), $urandom_range(0, 3),
                       $urandom_range(0, 3), 1'($urandom),
                       $urandom_range(0, 127), $urandom_range(0, 3),
                       (m == 2'b01) ? "R5" : (m == 2'b10) ? "R6" : "R7");
        end
        idle();
        idle();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule